// File: doc/BRIEF.md
# Manchester Line Decoder with One-Shot Clock Recovery

This block receives a Manchester-coded serial line. A logic 1 is sent as a low half-cell followed by a high half-cell, and a logic 0 as a high half-cell followed by a low half-cell. It produces a recovered bit clock, a decoded data bit and a one-cycle strobe for each decoded bit. It runs from a system clock much faster than the line rate. The nominal bit cell length is the parameter `BIT_TICKS`, given in system-clock cycles and divisible by 8.

Each transition at the middle of a bit cell starts a one-shot timer of 3/8 of a cell. When it expires the first time, the recovered clock rises and the level of the second half of the cell is captured. When it expires the second time, the recovered clock falls, a copy of the line is stored, and the timer stops. The next mid-cell transition is found as a difference between the live line and that stored copy. Because the timer is running while any bit-boundary transition occurs, those transitions are never taken as data. A line that stays quiet for too long sets a loss-of-signal flag, and the block returns to idle.

Top module: `manchester_rx`

## Requirements
- R1: While reset is asserted and after it is released with a quiet line, `rclk`, `bit_valid`, `los` and `rdata` are all 0.
- R2: The decoded `rdata` equals the level of the second half of the cell. A low-then-high cell gives 1 and a high-then-low cell gives 0. `rdata` changes only in a cycle where `bit_valid` is 1.
- R3: `line_in` passes through a two-flop synchronizer. `rclk` rises and `bit_valid` pulses for exactly one cycle at the clock edge that comes 3*BIT_TICKS/8 + 2 edges after the first edge that samples the triggering transition.
- R4: `rclk` stays high for exactly 3*BIT_TICKS/8 cycles and then falls.
- R5: Each bit cell produces exactly one strobe. Boundary transitions between equal bits, which occur while the timer runs, produce no extra strobe.
- R6: From idle, the first line edge is treated as a mid-cell transition. If that edge was really a cell boundary, one wrong bit (the first-half level) is delivered. After that, alternating data locks onto the true mid-cell transitions from the next cell on.
- R7: If no new mid-cell transition starts the timer within 3*BIT_TICKS/2 cycles of the last one, `los` rises at the edge 3*BIT_TICKS/2 + 2 edges after the one that sampled the last transition. The block then idles. `los` clears when the next line edge restarts decoding.
- R8: Cells whose length is within ±1/8 of `BIT_TICKS` still decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Manchester line, asynchronous |
| rclk | output | 1 | Recovered bit clock |
| rdata | output | 1 | Decoded bit, valid from the rising edge of `rclk` |
| bit_valid | output | 1 | One-cycle strobe with each rising edge of `rclk` |
| los | output | 1 | Loss of signal; set on timeout, cleared on the next edge |

## Verification
The bench sends runs of equal bits, whose boundary transitions would produce double strobes and inverted data if blanking failed. It checks the exact latency and high time of `rclk`, which any off-by-one in the timer compare would shift. It starts one frame on a cell boundary from idle: a decoder without self-alignment would keep delivering first-half levels instead of the single expected wrong bit. It also stretches and shrinks cells by 1/8 and times the loss-of-signal rise to the cycle, so a wrong timeout limit or a missing return to idle shows up as a missing or early flag.

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int BIT_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rclk,
  output logic rdata,
  output logic bit_valid,
  output logic los
);
  localparam int T3   = BIT_TICKS * 3 / 8;
  localparam int GAPN = BIT_TICKS * 3 / 2;
  localparam int TW   = $clog2(T3 + 1);
  localparam int GW   = $clog2(GAPN + 1);

  typedef enum logic [1:0] {IDLE, RISE_WAIT, FALL_WAIT, ARMED} st_t;

  st_t st;
  logic s1, s2, s3, held;
  logic [TW-1:0] tcnt;
  logic [GW-1:0] gap;

  wire line_edge = s2 ^ s3;
  wire mid_hit   = (st == ARMED) && (s2 != held);
  wire start     = ((st == IDLE) && line_edge) || mid_hit;
  wire tdone     = (tcnt == TW'(T3 - 1));
  wire gap_out   = (gap == GW'(GAPN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      tcnt      <= '0;
      gap       <= '0;
      held      <= 1'b0;
      rclk      <= 1'b0;
      rdata     <= 1'b0;
      bit_valid <= 1'b0;
      los       <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (st != IDLE && !gap_out) gap <= gap + 1'b1;
      if (start) begin
        st   <= RISE_WAIT;
        tcnt <= '0;
        gap  <= '0;
        los  <= 1'b0;
      end else begin
        case (st)
          RISE_WAIT: begin
            tcnt <= tcnt + 1'b1;
            if (tdone) begin
              st        <= FALL_WAIT;
              tcnt      <= '0;
              rclk      <= 1'b1;
              bit_valid <= 1'b1;
              rdata     <= s2;
            end
          end
          FALL_WAIT: begin
            tcnt <= tcnt + 1'b1;
            if (tdone) begin
              st   <= ARMED;
              tcnt <= '0;
              rclk <= 1'b0;
              held <= s2;
            end
          end
          ARMED: begin
            if (gap_out) begin
              st  <= IDLE;
              los <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/manchester_rx_chk.sv
module manchester_rx_chk #(
  parameter int BIT_TICKS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic rclk,
  input logic rdata,
  input logic bit_valid,
  input logic los
);
  localparam int T3 = BIT_TICKS * 3 / 8;
  int hc;

  always_ff @(posedge clk) begin
    if (!rst_n) hc <= 0;
    else hc <= rclk ? hc + 1 : 0;
  end

  a_r3_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> rclk && !$past(rclk));
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
  a_r3_rise_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rclk) |-> bit_valid);
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> $stable(rdata));
  a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rclk) |-> hc == T3);
  a_r7_los_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    los |-> !rclk && !bit_valid);
endmodule

bind manchester_rx manchester_rx_chk #(.BIT_TICKS(BIT_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rclk(rclk), .rdata(rdata),
  .bit_valid(bit_valid), .los(los)
);

// File: tb/sim_manchester_rx.sv
module sim_manchester_rx;
  localparam int BT   = 32;
  localparam int T3   = BT * 3 / 8;
  localparam int GAPN = BT * 3 / 2;

  logic clk = 1'b0, rst_n = 1'b0, line = 1'b0;
  logic rclk, rdata, bit_valid, los;

  manchester_rx #(.BIT_TICKS(BT)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line),
    .rclk(rclk), .rdata(rdata), .bit_valid(bit_valid), .los(los)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, nv = 0, hi = 0, last_mid = 0;
  bit fresh = 1'b0;
  bit q_bit[$];
  int q_stamp[$];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic bit next_rand();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  task automatic send_cell(input bit b, input int len);
    bit mis;
    mis = fresh && (line != !b);
    if (mis) begin
      q_bit.push_back(!b);
      q_stamp.push_back(cyc);
    end
    line = !b;
    repeat (len / 2) @(negedge clk);
    line = b;
    if (!mis) begin
      q_bit.push_back(b);
      q_stamp.push_back(cyc);
      last_mid = cyc;
    end
    fresh = 1'b0;
    repeat (len - len / 2) @(negedge clk);
  endtask

  task automatic los_check();
    while (cyc < last_mid + 2 + GAPN) @(negedge clk);
    chk(los == 1'b0, "R7", "los before timeout", int'(los), 0);
    @(negedge clk);
    chk(los == 1'b1, "R7", "los at timeout", int'(los), 1);
    chk(rclk == 1'b0, "R7", "rclk low while lost", int'(rclk), 0);
    chk(q_bit.size() == 0, "R5", "strobes still owed", q_bit.size(), 0);
    fresh = 1'b1;
  endtask

  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      nv++;
      if (q_bit.size() == 0) begin
        chk(1'b0, "R5", "extra strobe", 1, 0);
      end else begin
        bit eb;
        int es;
        eb = q_bit.pop_front();
        es = q_stamp.pop_front();
        chk(rdata == eb, "R2", "decoded bit", int'(rdata), int'(eb));
        chk(cyc - es == T3 + 3, "R3", "strobe latency", cyc - es, T3 + 3);
        chk(rclk == 1'b1, "R3", "rclk high with strobe", int'(rclk), 1);
        chk(los == 1'b0, "R7", "los clear while decoding", int'(los), 0);
      end
    end
    if (rst_n && rclk) hi++;
    else if (hi > 0) begin
      chk(hi == T3, "R4", "rclk high width", hi, T3);
      hi = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R5", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rclk == 0 && bit_valid == 0, "R1", "clock/strobe in reset", int'(rclk | bit_valid), 0);
    chk(los == 0 && rdata == 0, "R1", "los/data in reset", int'(los | rdata), 0);
    rst_n = 1'b1;
    fresh = 1'b1;
    repeat (6) @(negedge clk);
    chk(rclk == 0 && los == 0 && nv == 0, "R1", "quiet after reset", nv, 0);

    // random data, aligned start (R2, R3, R4)
    send_cell(!line, BT);
    for (int i = 0; i < 24; i++) send_cell(next_rand(), BT);
    chk(nv == 25, "R2", "frame A strobes", nv, 25);
    los_check();

    // run of equal bits: boundary edges blanked (R5)
    nv = 0;
    begin
      bit rb;
      rb = !line;
      for (int i = 0; i < 8; i++) send_cell(rb, BT);
    end
    chk(nv == 8, "R5", "one strobe per equal cell", nv, 8);
    los_check();

    // misaligned start, alternating data (R6)
    nv = 0;
    begin
      bit cb;
      cb = line;
      for (int i = 0; i < 10; i++) begin
        send_cell(cb, BT);
        cb = !cb;
      end
    end
    chk(nv == 10, "R6", "one wrong bit then lock", nv, 10);
    los_check();

    // cell length spread by 1/8 (R8)
    nv = 0;
    send_cell(!line, BT);
    for (int i = 0; i < 24; i++) send_cell(next_rand(), BT - BT / 8 + (i % 3) * (BT / 8));
    chk(nv == 25, "R8", "strobes with skewed cells", nv, 25);
    los_check();

    finish_run();
  end
endmodule